// File: doc/BRIEF.md
# Snoop Responder for a Transactional Cache

This block is the bus-watching half of a processor cache in a system where ordinary and transactional bus cycles share one bus. For each snooped request, it looks up a small tag and state array that is indexed by the low address bits. It then moves the hit line to its new coherence state and answers one cycle later in one of two ways: it supplies the line's data, or it refuses with a busy indication. A miss gives no answer, so main memory serves the request.

A mode input selects the rules. In regular mode the block answers as a plain shared/exclusive cache. In transactional mode each line also carries a transaction tag (empty, normal, commit-pending or abort-pending). A snoop that would take away data a running transaction depends on is refused with busy and leaves the line as it was. The requester's transaction then aborts instead of stealing the line.

The local side installs lines through a write port. When an install displaces a modified line, the block issues a write-back of the old line.

Top module: `snoop_responder`

## Requirements
- R1: While reset is high and in the first cycle after it, no response and no write-back is driven. Every line starts absent (state code 0 = invalid, transaction tag code 0 = empty).
- R2: A snoop is a miss, and produces neither data nor busy nor any state change, in three cases: the indexed line is invalid, its stored address differs from the snoop address, or the block is in transactional mode and the line's tag is empty.
- R3: A response appears exactly one cycle after the request. Request codes: 0 = read, 1 = read-for-ownership, 2 = transactional read, 3 = transactional read-for-ownership. A regular read (0) hitting a line in state 1 (valid), 2 (dirty) or 3 (reserved) returns the line data and leaves the line valid.
- R4: In regular mode, request codes 1 and 3 on a hit return the data and make the line invalid.
- R5: In regular mode, request code 2 on a hit returns the data and leaves the line valid.
- R6: In transactional mode, request code 2 on a dirty or reserved line is answered with busy and the line keeps its state. On a valid line it returns the data and the line stays valid.
- R7: In transactional mode, request code 3 on a line tagged 2 (commit-pending) or 3 (abort-pending) is answered with busy and leaves the line unchanged. On a line tagged 1 (normal) it returns the data and invalidates the line.
- R8: In transactional mode, request codes 0 and 1 on a normal-tagged line behave as in regular mode. On a commit-pending or abort-pending line they are answered with busy and leave the line unchanged.
- R9: Busy and data-valid are never asserted together, and busy only follows a request made in transactional mode.
- R10: An install one cycle earlier raises the write-back output carrying the old line's address and data, but only when all three hold: the install replaces a dirty line, it is for a different address, and either the block is in regular mode or the old line is normal-tagged.
- R11: When an install and a snoop hit the same index in the same cycle, the snoop is answered from the old contents and the installed contents remain in the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_mode | input | 1 | 1 = transactional-cache rules, 0 = regular-cache rules |
| snp_valid | input | 1 | A snooped bus request is present |
| snp_kind | input | 2 | Request code (0 read, 1 read-for-ownership, 2 transactional read, 3 transactional read-for-ownership) |
| snp_addr | input | ADDR_W | Snooped line address |
| loc_we | input | 1 | Local install of a line |
| loc_addr | input | ADDR_W | Address of the installed line |
| loc_state | input | 2 | State of the installed line (0 invalid, 1 valid, 2 dirty, 3 reserved) |
| loc_ttag | input | 2 | Transaction tag of the installed line (0 empty, 1 normal, 2 commit-pending, 3 abort-pending) |
| loc_data | input | DATA_W | Data of the installed line |
| rsp_data_vld | output | 1 | Data is supplied this cycle |
| rsp_busy | output | 1 | Request refused |
| rsp_data | output | DATA_W | Supplied line data |
| wb_vld | output | 1 | Write-back of a displaced dirty line |
| wb_addr | output | ADDR_W | Address of the written-back line |
| wb_data | output | DATA_W | Data of the written-back line |

## Verification
The bench compares the block on every clock against a behavioural line model, and targets these cases:

- **Owned line under a transactional read.** A design that surrenders an owned line to a transactional read would show data where busy belongs. The line would also drop to valid, so a repeated request would then succeed.
- **Empty-tagged line in transactional mode.** It is probed so that a lookup ignoring the tag shows up as a false hit.
- **Same-cycle install and snoop to one index.** A wrong priority either answers from the new contents or leaves the snoop's state update in the array. A follow-up snoop to the new address exposes the second fault.
- **Write-back conditions.** Same-address installs, clean victims and abort-pending dirty victims are each driven, so a write-back rule that is too loose fires where it must stay quiet.

// File: rtl/snp_pkg.sv
package snp_pkg;

    typedef enum logic [1:0] {
        ST_INV  = 2'd0,
        ST_VAL  = 2'd1,
        ST_DIRT = 2'd2,
        ST_RSV  = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        TT_EMPTY = 2'd0,
        TT_NORM  = 2'd1,
        TT_XCOM  = 2'd2,
        TT_XABT  = 2'd3
    } tx_tag_e;

    typedef enum logic [1:0] {
        K_RD   = 2'd0,
        K_RFO  = 2'd1,
        K_TRD  = 2'd2,
        K_TRFO = 2'd3
    } snp_kind_e;

    typedef struct packed {
        logic     busy;
        logic     supply;
        line_st_e next_st;
    } snp_dec_t;

    function automatic logic is_owned(input line_st_e st);
        return (st == ST_DIRT) || (st == ST_RSV);
    endfunction

    function automatic logic is_tx_tagged(input tx_tag_e tt);
        return (tt == TT_XCOM) || (tt == TT_XABT);
    endfunction

    // Response rule table for one present line.
    function automatic snp_dec_t decide(input snp_kind_e k, input logic tx,
                                        input line_st_e st, input tx_tag_e tt,
                                        input logic present);
        snp_dec_t d;
        logic     guarded;
        d.busy    = 1'b0;
        d.supply  = 1'b0;
        d.next_st = st;
        guarded   = tx && is_tx_tagged(tt);
        if (present) begin
            unique case (k)
                K_RD: begin
                    if (guarded) d.busy = 1'b1;
                    else begin
                        d.supply  = 1'b1;
                        d.next_st = ST_VAL;
                    end
                end
                K_RFO, K_TRFO: begin
                    if (guarded) d.busy = 1'b1;
                    else begin
                        d.supply  = 1'b1;
                        d.next_st = ST_INV;
                    end
                end
                K_TRD: begin
                    if (tx && is_owned(st)) d.busy = 1'b1;
                    else begin
                        d.supply  = 1'b1;
                        d.next_st = ST_VAL;
                    end
                end
                default: ;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/snp_line_array.sv
module snp_line_array
    import snp_pkg::*;
#(
    parameter int NLINES = 8,
    parameter int TAG_W  = 13,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst,
    // snoop read port and state update
    input  logic [IDX_W-1:0]  s_idx,
    output logic [TAG_W-1:0]  s_tag,
    output line_st_e          s_st,
    output tx_tag_e           s_tt,
    output logic [DATA_W-1:0] s_dat,
    input  logic              s_upd,
    input  line_st_e          s_new_st,
    // install read port and write
    input  logic [IDX_W-1:0]  i_idx,
    output logic [TAG_W-1:0]  i_tag,
    output line_st_e          i_st,
    output tx_tag_e           i_tt,
    output logic [DATA_W-1:0] i_dat,
    input  logic              i_we,
    input  logic [TAG_W-1:0]  i_new_tag,
    input  line_st_e          i_new_st,
    input  tx_tag_e           i_new_tt,
    input  logic [DATA_W-1:0] i_new_dat
);
    logic [TAG_W-1:0]  tag_q [NLINES];
    line_st_e          st_q  [NLINES];
    tx_tag_e           tt_q  [NLINES];
    logic [DATA_W-1:0] dat_q [NLINES];

    assign s_tag = tag_q[s_idx];
    assign s_st  = st_q[s_idx];
    assign s_tt  = tt_q[s_idx];
    assign s_dat = dat_q[s_idx];
    assign i_tag = tag_q[i_idx];
    assign i_st  = st_q[i_idx];
    assign i_tt  = tt_q[i_idx];
    assign i_dat = dat_q[i_idx];

    // The install is written last, so it overrides a snoop update to the same index.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NLINES; i++) begin
                st_q[i] <= ST_INV;
                tt_q[i] <= TT_EMPTY;
            end
        end else begin
            if (s_upd) st_q[s_idx] <= s_new_st;
            if (i_we) begin
                st_q[i_idx] <= i_new_st;
                tt_q[i_idx] <= i_new_tt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (i_we) begin
            tag_q[i_idx] <= i_new_tag;
            dat_q[i_idx] <= i_new_dat;
        end
    end
endmodule

// File: rtl/snp_rule_unit.sv
module snp_rule_unit
    import snp_pkg::*;
#(
    parameter int TAG_W = 13
) (
    input  logic             req,
    input  logic             tx,
    input  snp_kind_e        kind,
    input  logic [TAG_W-1:0] req_tag,
    input  logic [TAG_W-1:0] line_tag,
    input  line_st_e         line_st,
    input  tx_tag_e          line_tt,
    output snp_dec_t         dec
);
    logic present;

    always_comb begin
        present = req && (line_tag == req_tag) && (line_st != ST_INV)
                  && (!tx || (line_tt != TT_EMPTY));
        dec = decide(kind, tx, line_st, line_tt, present);
    end
endmodule

// File: rtl/snp_victim_unit.sv
module snp_victim_unit
    import snp_pkg::*;
#(
    parameter int TAG_W = 13
) (
    input  logic             we,
    input  logic             tx,
    input  logic [TAG_W-1:0] new_tag,
    input  logic [TAG_W-1:0] old_tag,
    input  line_st_e         old_st,
    input  tx_tag_e          old_tt,
    output logic             need_wb
);
    always_comb begin
        need_wb = we && (old_st == ST_DIRT) && (old_tag != new_tag)
                  && (!tx || (old_tt == TT_NORM));
    end
endmodule

// File: rtl/snoop_responder.sv
module snoop_responder
    import snp_pkg::*;
#(
    parameter int NLINES = 8,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_mode,
    input  logic              snp_valid,
    input  logic [1:0]        snp_kind,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              loc_we,
    input  logic [ADDR_W-1:0] loc_addr,
    input  logic [1:0]        loc_state,
    input  logic [1:0]        loc_ttag,
    input  logic [DATA_W-1:0] loc_data,
    output logic              rsp_data_vld,
    output logic              rsp_busy,
    output logic [DATA_W-1:0] rsp_data,
    output logic              wb_vld,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data
);
    localparam int IDX_W = $clog2(NLINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  s_idx, i_idx;
    logic [TAG_W-1:0]  s_rtag, i_rtag;
    logic [TAG_W-1:0]  s_tag, i_tag;
    line_st_e          s_st, i_st;
    tx_tag_e           s_tt, i_tt;
    logic [DATA_W-1:0] s_dat, i_dat;
    snp_dec_t          dec;
    logic              need_wb;

    assign s_idx  = snp_addr[IDX_W-1:0];
    assign s_rtag = snp_addr[ADDR_W-1:IDX_W];
    assign i_idx  = loc_addr[IDX_W-1:0];
    assign i_rtag = loc_addr[ADDR_W-1:IDX_W];

    snp_line_array #(.NLINES(NLINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_array (
        .clk       (clk),
        .rst       (rst),
        .s_idx     (s_idx),
        .s_tag     (s_tag),
        .s_st      (s_st),
        .s_tt      (s_tt),
        .s_dat     (s_dat),
        .s_upd     (dec.supply),
        .s_new_st  (dec.next_st),
        .i_idx     (i_idx),
        .i_tag     (i_tag),
        .i_st      (i_st),
        .i_tt      (i_tt),
        .i_dat     (i_dat),
        .i_we      (loc_we),
        .i_new_tag (i_rtag),
        .i_new_st  (line_st_e'(loc_state)),
        .i_new_tt  (tx_tag_e'(loc_ttag)),
        .i_new_dat (loc_data)
    );

    snp_rule_unit #(.TAG_W(TAG_W)) u_rules (
        .req      (snp_valid),
        .tx       (tx_mode),
        .kind     (snp_kind_e'(snp_kind)),
        .req_tag  (s_rtag),
        .line_tag (s_tag),
        .line_st  (s_st),
        .line_tt  (s_tt),
        .dec      (dec)
    );

    snp_victim_unit #(.TAG_W(TAG_W)) u_victim (
        .we      (loc_we),
        .tx      (tx_mode),
        .new_tag (i_rtag),
        .old_tag (i_tag),
        .old_st  (i_st),
        .old_tt  (i_tt),
        .need_wb (need_wb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_data_vld <= 1'b0;
            rsp_busy     <= 1'b0;
            wb_vld       <= 1'b0;
        end else begin
            rsp_data_vld <= dec.supply;
            rsp_busy     <= dec.busy;
            wb_vld       <= need_wb;
        end
    end

    always_ff @(posedge clk) begin
        if (dec.supply) rsp_data <= s_dat;
        if (need_wb) begin
            wb_addr <= {i_tag, i_idx};
            wb_data <= i_dat;
        end
    end
endmodule

// File: rtl/snoop_responder_chk.sv
module snoop_responder_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              tx_mode,
    input logic              snp_valid,
    input logic              loc_we,
    input logic [ADDR_W-1:0] loc_addr,
    input logic [ADDR_W-1:0] wb_addr,
    input logic              rsp_data_vld,
    input logic              rsp_busy,
    input logic              wb_vld
);
    // R1
    quiet_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rsp_data_vld && !rsp_busy && !wb_vld));

    // R9
    busy_excl_data_chk: assert property (@(posedge clk) disable iff (rst)
        !(rsp_data_vld && rsp_busy));

    // R3
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_data_vld || rsp_busy) |-> $past(snp_valid));

    // R9
    busy_only_tx_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_busy |-> $past(tx_mode));

    // R10
    wb_follows_install_chk: assert property (@(posedge clk) disable iff (rst)
        wb_vld |-> ($past(loc_we) && (wb_addr != $past(loc_addr))));
endmodule

bind snoop_responder snoop_responder_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tx_mode      (tx_mode),
    .snp_valid    (snp_valid),
    .loc_we       (loc_we),
    .loc_addr     (loc_addr),
    .wb_addr      (wb_addr),
    .rsp_data_vld (rsp_data_vld),
    .rsp_busy     (rsp_busy),
    .wb_vld       (wb_vld)
);

// File: tb/tb_snoop_responder.sv
module tb_snoop_responder;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 8;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          tx_mode, snp_valid, loc_we;
    logic [1:0]    snp_kind, loc_state, loc_ttag;
    logic [AW-1:0] snp_addr, loc_addr;
    logic [DW-1:0] loc_data;
    logic          rsp_data_vld, rsp_busy, wb_vld;
    logic [DW-1:0] rsp_data, wb_data;
    logic [AW-1:0] wb_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    snoop_responder #(.NLINES(NL), .ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .tx_mode(tx_mode), .snp_valid(snp_valid),
        .snp_kind(snp_kind), .snp_addr(snp_addr), .loc_we(loc_we),
        .loc_addr(loc_addr), .loc_state(loc_state), .loc_ttag(loc_ttag),
        .loc_data(loc_data), .rsp_data_vld(rsp_data_vld), .rsp_busy(rsp_busy),
        .rsp_data(rsp_data), .wb_vld(wb_vld), .wb_addr(wb_addr), .wb_data(wb_data)
    );

    // behavioural line model
    int          m_st [NL];
    int          m_tt [NL];
    int          m_adr[NL];
    int unsigned m_dat[NL];

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        snp_valid = 0; snp_kind = 0; snp_addr = 0;
        loc_we = 0; loc_addr = 0; loc_state = 0; loc_ttag = 0; loc_data = 0;
    endtask

    // One clock: predict from the model, advance it, then compare the outputs.
    task automatic cycle();
        int  si, li, nst;
        bit  present, guarded, owned, e_dv, e_busy, e_wb;
        int unsigned e_dat, e_wbd;
        int  e_wba;
        si = int'(snp_addr) % NL;
        li = int'(loc_addr) % NL;
        present = snp_valid && m_st[si] != 0 && m_adr[si] == int'(snp_addr)
                  && (!tx_mode || m_tt[si] != 0);
        guarded = tx_mode && m_tt[si] >= 2;
        owned   = m_st[si] >= 2;
        e_dv = 0; e_busy = 0; nst = m_st[si];
        e_dat = m_dat[si];
        if (present) begin
            if (snp_kind == 2) begin
                if (tx_mode && owned) e_busy = 1;
                else begin e_dv = 1; nst = 1; end
            end else if (guarded) e_busy = 1;
            else if (snp_kind == 0) begin e_dv = 1; nst = 1; end
            else begin e_dv = 1; nst = 0; end
        end
        e_wb  = loc_we && m_st[li] == 2 && m_adr[li] != int'(loc_addr)
                && (!tx_mode || m_tt[li] == 1);
        e_wba = m_adr[li];
        e_wbd = m_dat[li];
        if (e_dv) m_st[si] = nst;
        if (loc_we) begin
            m_st[li]  = int'(loc_state);
            m_tt[li]  = int'(loc_ttag);
            m_adr[li] = int'(loc_addr);
            m_dat[li] = loc_data;
        end
        @(posedge clk);
        #2;
        check(rsp_data_vld == e_dv, cur_req, "data_vld", rsp_data_vld, e_dv);
        check(rsp_busy == e_busy, cur_req, "busy", rsp_busy, e_busy);
        if (e_dv) check(rsp_data == e_dat, cur_req, "data", rsp_data, e_dat);
        check(wb_vld == e_wb, cur_req, "wb_vld", wb_vld, e_wb);
        if (e_wb) begin
            check(int'(wb_addr) == e_wba, cur_req, "wb_addr", wb_addr, e_wba);
            check(wb_data == e_wbd, cur_req, "wb_data", wb_data, e_wbd);
        end
        // R9
        check(!(rsp_data_vld && rsp_busy), "R9", "busy&data", rsp_busy, 0);
        idle_inputs();
    endtask

    task automatic snoop(input int kind, input int addr);
        snp_valid = 1; snp_kind = 2'(kind); snp_addr = AW'(addr);
        cycle();
    endtask

    task automatic install(input int addr, input int st, input int tt, input int unsigned d);
        loc_we = 1; loc_addr = AW'(addr); loc_state = 2'(st); loc_ttag = 2'(tt); loc_data = d;
        cycle();
    endtask

    initial begin
        idle_inputs();
        tx_mode = 0;
        rst = 1;
        for (int i = 0; i < NL; i++) begin
            m_st[i] = 0; m_tt[i] = 0; m_adr[i] = 0; m_dat[i] = 0;
        end
        repeat (3) @(posedge clk);
        #2;
        cur_req = "R1";
        check(!rsp_data_vld && !rsp_busy && !wb_vld, "R1", "outputs in reset",
              {rsp_data_vld, rsp_busy, wb_vld}, 0);
        rst = 0;
        for (int i = 0; i < NL; i++) snoop(0, i);

        // regular mode
        cur_req = "R3";
        install(16'h0010, 1, 0, 32'hA0A0_0010);
        install(16'h0011, 2, 0, 32'hB1B1_0011);
        install(16'h0012, 3, 0, 32'hC2C2_0012);
        snoop(0, 16'h0011);
        cur_req = "R4";
        snoop(1, 16'h0011);
        cur_req = "R2";
        snoop(0, 16'h0011);
        snoop(0, 16'h0110);
        cur_req = "R5";
        snoop(2, 16'h0012);
        snoop(2, 16'h0012);
        cur_req = "R4";
        snoop(3, 16'h0010);
        snoop(0, 16'h0010);

        // transactional mode
        tx_mode = 1;
        cur_req = "R6";
        install(16'h0023, 2, 1, 32'hD3D3_0023);
        snoop(2, 16'h0023);
        snoop(2, 16'h0023);
        install(16'h0024, 1, 2, 32'hE4E4_0024);
        snoop(2, 16'h0024);
        cur_req = "R7";
        install(16'h0025, 2, 3, 32'hF5F5_0025);
        snoop(3, 16'h0025);
        snoop(3, 16'h0024);
        install(16'h0026, 3, 1, 32'h0606_0026);
        snoop(3, 16'h0026);
        snoop(0, 16'h0026);
        cur_req = "R8";
        snoop(0, 16'h0023);
        snoop(2, 16'h0023);
        snoop(1, 16'h0024);
        snoop(0, 16'h0025);
        install(16'h0027, 3, 1, 32'h0707_0027);
        snoop(1, 16'h0027);
        cur_req = "R2";
        install(16'h0020, 1, 0, 32'h1010_0020);
        snoop(0, 16'h0020);

        // write-back
        cur_req = "R10";
        tx_mode = 0;
        install(16'h0035, 2, 0, 32'h3535_0035);
        install(16'h0035, 2, 0, 32'h3535_9999);
        install(16'h0135, 1, 0, 32'h3535_0135);
        install(16'h0235, 1, 0, 32'h3535_0235);
        install(16'h0031, 2, 0, 32'h3131_0031);
        install(16'h0131, 2, 0, 32'h3131_0131);
        tx_mode = 1;
        install(16'h0032, 2, 3, 32'h3232_0032);
        install(16'h0132, 1, 1, 32'h3232_0132);
        install(16'h0033, 2, 1, 32'h3333_0033);
        install(16'h0133, 1, 1, 32'h3333_0133);

        // same-index install and snoop
        cur_req = "R11";
        tx_mode = 0;
        install(16'h0044, 3, 0, 32'h4444_0044);
        snp_valid = 1; snp_kind = 1; snp_addr = 16'h0044;
        loc_we = 1; loc_addr = 16'h0144; loc_state = 1; loc_ttag = 0; loc_data = 32'h4444_0144;
        cycle();
        snoop(0, 16'h0144);
        snoop(0, 16'h0044);

        // mixed traffic against the model
        cur_req = "R9";
        for (int n = 0; n < 1500; n++) begin
            int a;
            tx_mode   = 1'($urandom_range(0, 1));
            a         = int'($urandom_range(0, 1)) * 256 + int'($urandom_range(0, NL - 1));
            snp_valid = 1'($urandom_range(0, 1));
            snp_kind  = 2'($urandom_range(0, 3));
            snp_addr  = AW'(a);
            loc_we    = ($urandom_range(0, 3) == 0);
            loc_addr  = AW'(int'($urandom_range(0, 1)) * 256 + int'($urandom_range(0, NL - 1)));
            loc_state = 2'($urandom_range(0, 3));
            loc_ttag  = 2'($urandom_range(0, 3));
            loc_data  = $urandom();
            cycle();
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog %s actual=hung expected=finished", cur_req);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule